// File: doc/BRIEF.md
# Receive Character FIFO with Per-Character Error Status

This block sits between a serial receiver front end and the CPU. Each arriving character is stored in a small FIFO together with its own status tag: a framing/CRC error flag, a parity error flag that the block computes itself, and an overrun flag. The CPU sees the oldest character on the data output. A read strobe removes it, and a status view follows the character at the top of the queue.

Each error kind is kept under its own rule. The framing/CRC indication is not held: it always shows the flag of the character now at the top. A parity error is held from the moment it appears until the CPU issues an error-reset command. An overrun marks only the character that was overwritten, and it becomes sticky once that character has been read. A special-receive-condition interrupt request follows these status bits when receiver interrupts are enabled. The block also reports when the asynchronous transmitter has fully drained.

Top module: `rx_stat_fifo`

## Requirements
- R1: Characters leave in arrival order. `rd_data` shows the oldest stored character, and `char_avail` is high exactly while at least one character is stored. The capacity is DEPTH (3) characters.
- R2: A read strobe while the FIFO is empty changes nothing. `rd_data` keeps the last character read (0 after reset), and `char_avail` stays low.
- R3: With `par_en` high, a character has a parity error when the XOR of its data bits and `rx_par_bit` is 1 under even sense (`par_odd`=0), or 0 under odd sense (`par_odd`=1). With `par_en` low, no parity error is recorded.
- R4: `stat_parity` rises when a character with a parity error reaches the top. It stays high through later reads until `err_reset`.
- R5: `stat_frm_crc` equals the framing/CRC flag of the character at the top, and is 0 when the FIFO is empty. It is not held when that character is read. `err_reset` clears the flag of the current top character.
- R6: A character written while the FIFO is full and not being read replaces the newest stored character. Only that entry gets the overrun flag, and the count stays at DEPTH.
- R7: A write and a read in the same cycle on a full FIFO act as a read followed by a write. Nothing is lost and no overrun flag is set.
- R8: `stat_overrun` is high while the flagged character is at the top. Once that character is read, the bit stays high until `err_reset`, even with the FIFO empty.
- R9: With `rx_int_en` high, `special_irq` is the OR of `stat_parity`, `stat_overrun`, and (`async_mode`=1 and `stat_frm_crc`). A CRC flag in synchronous mode (`async_mode`=0) never requests an interrupt.
- R10: With `rx_int_en` low, `special_irq` stays low whatever the status bits show.
- R11: `all_sent` is 1 whenever `async_mode`=0. In asynchronous mode it is 1 only when `tx_busy`=0 and `tx_buf_empty`=1.
- R12: Reset empties the FIFO, clears all stored and held error bits, sets `rd_data` to 0 and drops `special_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Front end delivers a character this cycle |
| rx_data | input | DATA_W | Received character |
| rx_frm_crc_err | input | 1 | Framing error (async) or CRC mismatch (sync) for this character |
| rx_par_bit | input | 1 | Received parity bit |
| async_mode | input | 1 | 1 = asynchronous, 0 = synchronous/SDLC |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity sense, 0 = even |
| rx_int_en | input | 1 | Receiver interrupts enabled |
| rd_pop | input | 1 | CPU read strobe of the data register |
| err_reset | input | 1 | Error-reset command |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_buf_empty | input | 1 | Transmit buffer is empty |
| rd_data | output | DATA_W | Oldest character, or last character read when empty |
| char_avail | output | 1 | FIFO holds at least one character |
| stat_frm_crc | output | 1 | Framing/CRC status of the top character |
| stat_parity | output | 1 | Held parity error status |
| stat_overrun | output | 1 | Overrun status |
| special_irq | output | 1 | Special-receive-condition interrupt request |
| all_sent | output | 1 | Transmitter fully drained |

## Verification
The bench builds the block with its default DEPTH of 3 and DATA_W of 8. At that depth a fourth write without a read reaches the overwrite path, and the flagged entry then sits two reads below the top. This lets the bench show that the entries ahead of it stay clean. The bench also shows the bit becoming sticky only after the flagged character is read, and a simultaneous write and read at full occupancy taking the no-overrun path.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    // Status tag stored with each character
    typedef struct packed {
        logic frm;   // framing (async) or CRC mismatch (sync)
        logic par;   // parity check failed
        logic ovr;   // this entry was overwritten
    } rsf_flags_t;

    localparam rsf_flags_t FLAGS_CLEAR = '{frm: 1'b0, par: 1'b0, ovr: 1'b0};

    // Parity check: x is XOR of data and parity bit; odd sense expects 1
    function automatic logic parity_fails(input logic x, input logic odd_sense);
        return x ^ odd_sense;
    endfunction

    // Interrupt cause combining held and live status
    function automatic logic irq_cause(input logic par_s, input logic ovr_s,
                                       input logic frm_s, input logic is_async);
        return par_s | ovr_s | (frm_s & is_async);
    endfunction

endpackage

// File: rtl/rsf_store.sv
module rsf_store
    import rsf_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_frm,
    input  logic              push_par,
    input  logic              pop_req,
    input  logic              clr_top,
    output logic              top_valid,
    output rsf_flags_t        top_flags,
    output logic [DATA_W-1:0] out_data,
    output logic              do_pop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem_d [DEPTH];
    rsf_flags_t        mem_f [DEPTH];
    logic [PTR_W-1:0]  head_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] last_q;

    logic              full;
    logic              ovr_write;
    logic [PTR_W-1:0]  tail;
    logic [PTR_W-1:0]  newest;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  head_nxt;

    always_comb begin
        int unsigned s;
        s = 32'(head_q) + 32'(cnt_q);
        if (s >= 32'(DEPTH)) s = s - 32'(DEPTH);
        tail   = PTR_W'(s);
        newest = (tail == '0) ? PTR_W'(DEPTH - 1) : tail - 1'b1;
        head_nxt = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    end

    assign top_valid = (cnt_q != '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign do_pop    = pop_req & top_valid;
    assign ovr_write = push & full & ~do_pop;
    assign wr_idx    = ovr_write ? newest : tail;

    assign top_flags = top_valid ? mem_f[head_q] : FLAGS_CLEAR;
    assign out_data  = top_valid ? mem_d[head_q] : last_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_d[i] <= '0;
                    mem_f[i] <= FLAGS_CLEAR;
                end else if (push && wr_idx == PTR_W'(i)) begin
                    mem_d[i] <= push_data;
                    mem_f[i] <= '{frm: push_frm, par: push_par, ovr: ovr_write};
                end else if (clr_top && top_valid && head_q == PTR_W'(i)) begin
                    mem_f[i] <= FLAGS_CLEAR;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            if (do_pop) begin
                head_q <= head_nxt;
                last_q <= mem_d[head_q];
            end
            if (push && !do_pop && !full)
                cnt_q <= cnt_q + 1'b1;
            else if (!push && do_pop)
                cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/rsf_status.sv
module rsf_status
    import rsf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       top_valid,
    input  rsf_flags_t top_flags,
    input  logic       do_pop,
    input  logic       err_reset,
    input  logic       async_mode,
    input  logic       rx_int_en,
    output logic       stat_frm,
    output logic       stat_par,
    output logic       stat_ovr,
    output logic       irq
);
    logic par_held_q;
    logic ovr_held_q;

    always_ff @(posedge clk) begin
        if (rst || err_reset) begin
            par_held_q <= 1'b0;
            ovr_held_q <= 1'b0;
        end else if (do_pop) begin
            if (top_flags.par) par_held_q <= 1'b1;
            if (top_flags.ovr) ovr_held_q <= 1'b1;
        end
    end

    assign stat_frm = top_valid & top_flags.frm;
    assign stat_par = par_held_q | (top_valid & top_flags.par);
    assign stat_ovr = ovr_held_q | (top_valid & top_flags.ovr);
    assign irq      = rx_int_en & irq_cause(stat_par, stat_ovr, stat_frm, async_mode);

endmodule

// File: rtl/rsf_tx_idle.sv
module rsf_tx_idle (
    input  logic async_mode,
    input  logic tx_busy,
    input  logic tx_buf_empty,
    output logic all_sent
);
    assign all_sent = ~async_mode | (~tx_busy & tx_buf_empty);
endmodule

// File: rtl/rx_stat_fifo.sv
module rx_stat_fifo
    import rsf_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_frm_crc_err,
    input  logic              rx_par_bit,
    input  logic              async_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rx_int_en,
    input  logic              rd_pop,
    input  logic              err_reset,
    input  logic              tx_busy,
    input  logic              tx_buf_empty,
    output logic [DATA_W-1:0] rd_data,
    output logic              char_avail,
    output logic              stat_frm_crc,
    output logic              stat_parity,
    output logic              stat_overrun,
    output logic              special_irq,
    output logic              all_sent
);
    logic       in_par_err;
    logic       top_valid;
    logic       do_pop;
    rsf_flags_t top_flags;

    assign in_par_err = par_en & parity_fails(^{rx_data, rx_par_bit}, par_odd);

    rsf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_valid),
        .push_data (rx_data),
        .push_frm  (rx_frm_crc_err),
        .push_par  (in_par_err),
        .pop_req   (rd_pop),
        .clr_top   (err_reset),
        .top_valid (top_valid),
        .top_flags (top_flags),
        .out_data  (rd_data),
        .do_pop    (do_pop)
    );

    rsf_status u_status (
        .clk        (clk),
        .rst        (rst),
        .top_valid  (top_valid),
        .top_flags  (top_flags),
        .do_pop     (do_pop),
        .err_reset  (err_reset),
        .async_mode (async_mode),
        .rx_int_en  (rx_int_en),
        .stat_frm   (stat_frm_crc),
        .stat_par   (stat_parity),
        .stat_ovr   (stat_overrun),
        .irq        (special_irq)
    );

    rsf_tx_idle u_tx_idle (
        .async_mode   (async_mode),
        .tx_busy      (tx_busy),
        .tx_buf_empty (tx_buf_empty),
        .all_sent     (all_sent)
    );

    assign char_avail = top_valid;

endmodule

// File: rtl/rx_stat_fifo_chk.sv
module rx_stat_fifo_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              async_mode,
    input logic              rx_int_en,
    input logic              rd_pop,
    input logic              err_reset,
    input logic [DATA_W-1:0] rd_data,
    input logic              char_avail,
    input logic              stat_frm_crc,
    input logic              stat_parity,
    input logic              stat_overrun,
    input logic              special_irq,
    input logic              all_sent
);
    a_r1_avail_after_write: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> char_avail);

    a_r2_empty_read_inert: assert property (@(posedge clk) disable iff (rst)
        (!char_avail && rd_pop && !rx_valid) |=> ($stable(rd_data) && !char_avail));

    a_r4_parity_holds: assert property (@(posedge clk) disable iff (rst)
        (stat_parity && !err_reset) |=> stat_parity);

    a_r5_frm_zero_when_empty: assert property (@(posedge clk) disable iff (rst)
        !char_avail |-> !stat_frm_crc);

    a_r8_overrun_holds: assert property (@(posedge clk) disable iff (rst)
        (stat_overrun && !err_reset) |=> stat_overrun);

    a_r10_no_irq_disabled: assert property (@(posedge clk) disable iff (rst)
        !rx_int_en |-> !special_irq);

    a_r11_sync_all_sent: assert property (@(posedge clk) disable iff (rst)
        !async_mode |-> all_sent);

    a_r12_err_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (err_reset && !rd_pop && !rx_valid) |=> (!stat_parity && !stat_overrun && !stat_frm_crc));

endmodule

bind rx_stat_fifo rx_stat_fifo_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rx_stat_fifo.sv
module tb_rx_stat_fifo;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_valid, rx_frm_crc_err, rx_par_bit;
    logic [DW-1:0] rx_data;
    logic          async_mode, par_en, par_odd, rx_int_en;
    logic          rd_pop, err_reset, tx_busy, tx_buf_empty;
    logic [DW-1:0] rd_data;
    logic          char_avail, stat_frm_crc, stat_parity, stat_overrun;
    logic          special_irq, all_sent;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_stat_fifo #(.DEPTH(3), .DATA_W(DW)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_c(input logic [DW-1:0] d, input logic frm, input logic pb);
        rx_valid = 1'b1; rx_data = d; rx_frm_crc_err = frm; rx_par_bit = pb;
        tick();
        rx_valid = 1'b0; rx_frm_crc_err = 1'b0; rx_par_bit = 1'b0;
    endtask

    task automatic pop_c();
        rd_pop = 1'b1; tick(); rd_pop = 1'b0;
    endtask

    task automatic ereset();
        err_reset = 1'b1; tick(); err_reset = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 avail", char_avail, 0);
        chk("R12 rd_data", rd_data, 0);
        chk("R12 status", {stat_frm_crc, stat_parity, stat_overrun}, 0);
        chk("R12 irq", special_irq, 0);
    endtask

    task automatic t_order();
        push_c(8'hA1, 0, 0); push_c(8'hB2, 0, 0); push_c(8'hC3, 0, 0);
        chk("R1 avail", char_avail, 1);
        chk("R1 first", rd_data, 8'hA1);
        pop_c(); chk("R1 second", rd_data, 8'hB2);
        pop_c(); chk("R1 third", rd_data, 8'hC3);
        pop_c(); chk("R1 empty", char_avail, 0);
        chk("R2 last kept", rd_data, 8'hC3);
        pop_c(); chk("R2 empty read data", rd_data, 8'hC3);
        chk("R2 empty read avail", char_avail, 0);
        chk("R2 no status", {stat_frm_crc, stat_parity, stat_overrun}, 0);
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        push_c(8'h01, 0, 0);            // xor 1, even sense -> error
        push_c(8'h03, 0, 0);            // xor 0 -> fine
        chk("R3 even error", stat_parity, 1);
        chk("R9 parity irq", special_irq, 1);
        pop_c(); chk("R4 held after read", stat_parity, 1);
        pop_c(); chk("R4 held when empty", stat_parity, 1);
        ereset(); chk("R4 cleared", stat_parity, 0);
        chk("R9 irq dropped", special_irq, 0);
        par_odd = 1'b1;
        push_c(8'h01, 0, 0);            // xor 1, odd sense -> fine
        chk("R3 odd ok", stat_parity, 0);
        pop_c();
        par_en = 1'b0; par_odd = 1'b0;
        push_c(8'h01, 0, 0);            // would fail, but checking off
        chk("R3 disabled", stat_parity, 0);
        pop_c();
    endtask

    task automatic t_frm();
        push_c(8'h10, 1, 0); push_c(8'h11, 0, 0);
        chk("R5 frm top", stat_frm_crc, 1);
        chk("R9 frm irq async", special_irq, 1);
        pop_c(); chk("R5 not held", stat_frm_crc, 0);
        chk("R9 irq follows frm", special_irq, 0);
        pop_c();
        push_c(8'h12, 1, 0);
        ereset(); chk("R5 err_reset clears", stat_frm_crc, 0);
        pop_c();
        async_mode = 1'b0; tx_busy = 1'b1; tx_buf_empty = 1'b0;
        push_c(8'h13, 1, 0);
        chk("R5 crc shown sync", stat_frm_crc, 1);
        chk("R9 no crc irq", special_irq, 0);
        chk("R11 sync all_sent", all_sent, 1);
        pop_c();
        async_mode = 1'b1; tx_busy = 1'b0; tx_buf_empty = 1'b1;
    endtask

    task automatic t_overrun();
        push_c(8'h20, 0, 0); push_c(8'h21, 0, 0);
        push_c(8'h22, 0, 0); push_c(8'h23, 0, 0);
        chk("R6 top unchanged", rd_data, 8'h20);
        chk("R6 top not flagged", stat_overrun, 0);
        chk("R6 no irq yet", special_irq, 0);
        pop_c(); chk("R6 second", rd_data, 8'h21);
        chk("R6 second not flagged", stat_overrun, 0);
        pop_c(); chk("R6 replaced newest", rd_data, 8'h23);
        chk("R8 flagged at top", stat_overrun, 1);
        chk("R9 ovr irq", special_irq, 1);
        pop_c(); chk("R6 count kept", char_avail, 0);
        chk("R8 held empty", stat_overrun, 1);
        push_c(8'h30, 0, 0); chk("R8 held later char", special_irq, 1);
        ereset(); chk("R8 cleared", stat_overrun, 0);
        pop_c();
    endtask

    task automatic t_full_pushpop();
        push_c(8'h40, 0, 0); push_c(8'h41, 0, 0); push_c(8'h42, 0, 0);
        rd_pop = 1'b1; rx_valid = 1'b1; rx_data = 8'h43;
        tick();
        rd_pop = 1'b0; rx_valid = 1'b0;
        chk("R7 top", rd_data, 8'h41); chk("R7 no ovr", stat_overrun, 0);
        pop_c(); chk("R7 next", rd_data, 8'h42);
        pop_c(); chk("R7 last", rd_data, 8'h43);
        chk("R7 last no ovr", stat_overrun, 0);
        pop_c(); chk("R7 empty", char_avail, 0);
    endtask

    task automatic t_int_en();
        rx_int_en = 1'b0; par_en = 1'b1;
        push_c(8'h01, 1, 0);
        chk("R10 status set", stat_parity, 1);
        chk("R10 irq masked", special_irq, 0);
        rx_int_en = 1'b1; #1;
        chk("R9 irq enabled", special_irq, 1);
        ereset(); pop_c(); par_en = 1'b0;
    endtask

    task automatic t_all_sent();
        async_mode = 1'b1;
        tx_busy = 1'b1; tx_buf_empty = 1'b1; #1; chk("R11 busy", all_sent, 0);
        tx_busy = 1'b0; tx_buf_empty = 1'b0; #1; chk("R11 buffer full", all_sent, 0);
        tx_buf_empty = 1'b1; #1; chk("R11 drained", all_sent, 1);
        async_mode = 1'b0; tx_busy = 1'b1; #1; chk("R11 sync", all_sent, 1);
        async_mode = 1'b1; tx_busy = 1'b0;
    endtask

    initial begin
        rst = 1'b1; rx_valid = 0; rx_data = 0; rx_frm_crc_err = 0; rx_par_bit = 0;
        async_mode = 1; par_en = 0; par_odd = 0; rx_int_en = 1;
        rd_pop = 0; err_reset = 0; tx_busy = 0; tx_buf_empty = 1;
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_order();
        t_parity();
        t_frm();
        t_overrun();
        t_full_pushpop();
        t_int_en();
        t_all_sent();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule